// File: doc/BRIEF.md
# Boot-Time Parameter Memory Loader

This block brings a processor's memories into a known state after reset. When the synchronous active-low reset is released, it runs one fixed-length start-up sequence. It sends a single clear strobe to the control registers. It then copies a constant coefficient table, one word per cycle, into every location of the parameter memory. After that it writes zero into every word of the sample memory. When the whole window has elapsed, it raises a ready flag, and the flag stays high until the next reset.

The loader owns both memory write ports for the whole window. A write request from the host control port that arrives before ready is high is discarded, and a sticky flag records the loss. Once ready is high, host write requests pass straight through to the memory that the host selects, in the same cycle. The memories themselves and the signal-processing datapath that reads them sit outside this block.

Top module: `param_boot_loader`

## Requirements
- R1: While reset is low, and in the first cycle after reset is first released, no memory write, no clear strobe, no ready and no drop flag is output.
- R2: `regs_clr` is high for exactly one cycle, the cycle that follows the first rising clock edge after reset release (called cycle 1 below, where cycle k follows the k-th edge).
- R3: In cycles 1 to 256, `prm_we` is high, `prm_addr` counts 0 to 255 in ascending order, and `prm_wdata` is bits [23:0] of ((a × 2654435761) mod 2^32) XOR (a × 128) for address a. No other parameter write happens while `ready` is low.
- R4: In cycles 257 to 768, `dat_we` is high, `dat_addr` counts 0 to 511 in ascending order, and `dat_wdata` is zero. No other sample-memory write happens while `ready` is low.
- R5: `ready` is low through cycle 1024, is high from cycle 1025, and stays high until reset.
- R6: A host write request (`hst_we` high) made while `ready` is low causes no activity on either memory write port.
- R7: `wr_drop_err` goes high in the cycle after an edge that samples `hst_we` high while `ready` is low. Only reset clears it.
- R8: While `ready` is high, `hst_we` with `hst_sel`=0 writes `hst_wdata` to parameter address `hst_addr[7:0]`, and with `hst_sel`=1 writes to sample address `hst_addr`. Both happen in the same cycle. No write appears when `hst_we` is low.
- R9: Asserting reset in the middle of the sequence stops it. On release, the whole sequence starts again from parameter address 0 with a fresh 1024-cycle window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset; release starts the sequence |
| hst_we | input | 1 | Host control-port write request |
| hst_sel | input | 1 | Host target: 0 parameter memory, 1 sample memory |
| hst_addr | input | 9 | Host write address |
| hst_wdata | input | 24 | Host write data |
| prm_we | output | 1 | Parameter memory write enable |
| prm_addr | output | 8 | Parameter memory write address |
| prm_wdata | output | 24 | Parameter memory write data |
| dat_we | output | 1 | Sample memory write enable |
| dat_addr | output | 9 | Sample memory write address |
| dat_wdata | output | 24 | Sample memory write data |
| regs_clr | output | 1 | One-cycle clear strobe for the control registers |
| ready | output | 1 | Sequence complete; host writes accepted |
| wr_drop_err | output | 1 | Sticky: a host write was discarded during the sequence |

## Verification
The case that is hardest to reach from the ports is a reset that lands partway through the sequence. Such a reset must throw away the progress already made and restart the counting from address 0. The ready and drop-flag timing must also be measured from the new release, not the first one. The stimulus releases reset and lets the parameter copy run past its midpoint. It then pulls reset low again and flushes the expected-write queue. It refills the queue with the complete sequence, so that any leftover count or early ready shows up as a write that was not expected, a write at the wrong address, or a ready edge in the wrong cycle. The stimulus also sends host writes during both the copy phase and the zeroing phase, to show that they are discarded in each phase.

// File: rtl/boot_loader_pkg.sv
// Package: shared types and the constant coefficient table for the
// boot-time memory loader. Assumes coefficient words of at most 32 bits.
package boot_loader_pkg;

    // Phase of the start-up window, decoded from the cycle counter.
    typedef enum logic [2:0] {
        PH_HOLD  = 3'd0,
        PH_COEF  = 3'd1,
        PH_ZERO  = 3'd2,
        PH_TAIL  = 3'd3,
        PH_READY = 3'd4
    } boot_phase_t;

    // Constant coefficient for table address a; callers keep the low bits.
    function automatic logic [31:0] coef_word(input logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ (a << 7);
    endfunction

endpackage

// File: rtl/bl_sequencer.sv
// Sequencer: counts the fixed start-up window after reset release and
// decodes which memory is written in each cycle. Assumes the coefficient
// copy and the zeroing pass both fit inside the window.
module bl_sequencer
    import boot_loader_pkg::*;
#(
    parameter int INIT_CYCLES = 1024,
    parameter int PARAM_DEPTH = 256,
    parameter int DATA_DEPTH  = 512
) (
    input  logic                           clk,
    input  logic                           rst_n,
    output logic                           busy,
    output logic                           done,
    output logic                           clr_pulse,
    output logic                           seq_prm_we,
    output logic [$clog2(PARAM_DEPTH)-1:0] seq_prm_addr,
    output logic                           seq_dat_we,
    output logic [$clog2(DATA_DEPTH)-1:0]  seq_dat_addr
);
    localparam int CW   = $clog2(INIT_CYCLES);
    localparam int PAW  = $clog2(PARAM_DEPTH);
    localparam int DAW  = $clog2(DATA_DEPTH);
    localparam int ZEND = PARAM_DEPTH + DATA_DEPTH;
    localparam logic [CW-1:0] LAST = CW'(INIT_CYCLES - 1);

    generate
        if (ZEND > INIT_CYCLES) begin : g_bad_window
            $error("copy and zeroing do not fit in the start-up window");
        end
        if (DAW > CW) begin : g_bad_width
            $error("sample memory wider than the window counter");
        end
    endgenerate

    logic [CW-1:0] cnt;
    logic [CW-1:0] zero_off;
    boot_phase_t   phase;

    // Start the window on the first edge after release; advance it while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            done <= 1'b0;
            cnt  <= '0;
        end else if (busy) begin
            if (cnt == LAST) begin
                busy <= 1'b0;
                done <= 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end else if (!done) begin
            busy <= 1'b1;
        end
    end

    // Decode the phase of the window from the counter.
    always_comb begin
        phase = PH_HOLD;
        if (done) begin
            phase = PH_READY;
        end else if (busy) begin
            if (int'(cnt) < PARAM_DEPTH) begin
                phase = PH_COEF;
            end else if (int'(cnt) < ZEND) begin
                phase = PH_ZERO;
            end else begin
                phase = PH_TAIL;
            end
        end
    end

    // Offset of the counter into the zeroing pass.
    always_comb begin
        zero_off = cnt - CW'(PARAM_DEPTH);
    end

    // Drive the sequencer-side write requests and the clear strobe.
    always_comb begin
        seq_prm_we   = (phase == PH_COEF);
        seq_prm_addr = cnt[PAW-1:0];
        seq_dat_we   = (phase == PH_ZERO);
        seq_dat_addr = zero_off[DAW-1:0];
        clr_pulse    = busy && (cnt == '0);
    end

endmodule

// File: rtl/bl_coef_rom.sv
// Constant coefficient table: maps a parameter address to its boot value.
// Purely combinational; assumes WORD_W is 32 bits or fewer.
module bl_coef_rom
    import boot_loader_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int WORD_W = 24
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [WORD_W-1:0] word
);
    logic [31:0] full;

    generate
        if (WORD_W > 32) begin : g_bad_word
            $error("coefficient words limited to 32 bits");
        end
    endgenerate

    // Evaluate the table function and keep the low word bits.
    always_comb begin
        full = coef_word(32'(addr));
        word = full[WORD_W-1:0];
    end

endmodule

// File: rtl/bl_port_arb.sv
// Write-port arbiter: gives both memory write ports to the sequencer until
// the window completes, then passes host writes through. Host requests made
// earlier are dropped and recorded in a sticky flag.
module bl_port_arb #(
    parameter int PAW    = 8,
    parameter int DAW    = 9,
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  logic              seq_prm_we,
    input  logic [PAW-1:0]    seq_prm_addr,
    input  logic [WORD_W-1:0] seq_prm_data,
    input  logic              seq_dat_we,
    input  logic [DAW-1:0]    seq_dat_addr,
    input  logic              hst_we,
    input  logic              hst_sel,
    input  logic [DAW-1:0]    hst_addr,
    input  logic [WORD_W-1:0] hst_wdata,
    output logic              prm_we,
    output logic [PAW-1:0]    prm_addr,
    output logic [WORD_W-1:0] prm_wdata,
    output logic              dat_we,
    output logic [DAW-1:0]    dat_addr,
    output logic [WORD_W-1:0] dat_wdata,
    output logic              drop_err
);
    // Select the owner of each write port.
    always_comb begin
        if (done) begin
            prm_we    = hst_we && !hst_sel;
            prm_addr  = hst_addr[PAW-1:0];
            prm_wdata = hst_wdata;
            dat_we    = hst_we && hst_sel;
            dat_addr  = hst_addr;
            dat_wdata = hst_wdata;
        end else begin
            prm_we    = seq_prm_we;
            prm_addr  = seq_prm_addr;
            prm_wdata = seq_prm_data;
            dat_we    = seq_dat_we;
            dat_addr  = seq_dat_addr;
            dat_wdata = '0;
        end
    end

    // Record any host request that arrived before the window completed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drop_err <= 1'b0;
        end else if (hst_we && !done) begin
            drop_err <= 1'b1;
        end
    end

endmodule

// File: rtl/param_boot_loader.sv
// Top: boot-time loader. After reset release it pulses a register clear,
// copies the coefficient table into the parameter memory, zeroes the sample
// memory, and raises ready when the fixed window ends. Assumes the memories
// capture writes on the rising clock edge.
module param_boot_loader #(
    parameter int INIT_CYCLES = 1024,
    parameter int PARAM_DEPTH = 256,
    parameter int DATA_DEPTH  = 512,
    parameter int WORD_W      = 24,
    localparam int PAW        = $clog2(PARAM_DEPTH),
    localparam int DAW        = $clog2(DATA_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hst_we,
    input  logic              hst_sel,
    input  logic [DAW-1:0]    hst_addr,
    input  logic [WORD_W-1:0] hst_wdata,
    output logic              prm_we,
    output logic [PAW-1:0]    prm_addr,
    output logic [WORD_W-1:0] prm_wdata,
    output logic              dat_we,
    output logic [DAW-1:0]    dat_addr,
    output logic [WORD_W-1:0] dat_wdata,
    output logic              regs_clr,
    output logic              ready,
    output logic              wr_drop_err
);
    logic              busy;
    logic              done;
    logic              seq_prm_we;
    logic [PAW-1:0]    seq_prm_addr;
    logic              seq_dat_we;
    logic [DAW-1:0]    seq_dat_addr;
    logic [WORD_W-1:0] coef;

    bl_sequencer #(
        .INIT_CYCLES (INIT_CYCLES),
        .PARAM_DEPTH (PARAM_DEPTH),
        .DATA_DEPTH  (DATA_DEPTH)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .busy         (busy),
        .done         (done),
        .clr_pulse    (regs_clr),
        .seq_prm_we   (seq_prm_we),
        .seq_prm_addr (seq_prm_addr),
        .seq_dat_we   (seq_dat_we),
        .seq_dat_addr (seq_dat_addr)
    );

    bl_coef_rom #(
        .ADDR_W (PAW),
        .WORD_W (WORD_W)
    ) u_rom (
        .addr (seq_prm_addr),
        .word (coef)
    );

    bl_port_arb #(
        .PAW    (PAW),
        .DAW    (DAW),
        .WORD_W (WORD_W)
    ) u_arb (
        .clk          (clk),
        .rst_n        (rst_n),
        .done         (done),
        .seq_prm_we   (seq_prm_we),
        .seq_prm_addr (seq_prm_addr),
        .seq_prm_data (coef),
        .seq_dat_we   (seq_dat_we),
        .seq_dat_addr (seq_dat_addr),
        .hst_we       (hst_we),
        .hst_sel      (hst_sel),
        .hst_addr     (hst_addr),
        .hst_wdata    (hst_wdata),
        .prm_we       (prm_we),
        .prm_addr     (prm_addr),
        .prm_wdata    (prm_wdata),
        .dat_we       (dat_we),
        .dat_addr     (dat_addr),
        .dat_wdata    (dat_wdata),
        .drop_err     (wr_drop_err)
    );

    // Ready is the completion flag of the window.
    always_comb begin
        ready = done;
    end

endmodule

// File: rtl/bl_checker.sv
// Checker: temporal properties of the loader, observed at its ports.
module bl_checker #(
    parameter int PAW    = 8,
    parameter int DAW    = 9,
    parameter int WORD_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hst_we,
    input logic              hst_sel,
    input logic              prm_we,
    input logic [PAW-1:0]    prm_addr,
    input logic              dat_we,
    input logic [DAW-1:0]    dat_addr,
    input logic [WORD_W-1:0] dat_wdata,
    input logic              regs_clr,
    input logic              ready,
    input logic              wr_drop_err
);
    // R1: a reset edge leaves ready and the drop flag low
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!ready && !wr_drop_err));

    // R2: the clear strobe never lasts two cycles
    a_r2_clr_single: assert property (@(posedge clk) disable iff (!rst_n)
        regs_clr |=> !regs_clr);

    // R3: table copy walks the addresses one step per cycle
    a_r3_prm_step: assert property (@(posedge clk) disable iff (!rst_n)
        (prm_we && !ready && prm_addr != '1) |=>
        (prm_we && prm_addr == $past(prm_addr) + 1'b1));

    // R4: zeroing starts right after the last table word
    a_r4_zero_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (prm_we && !ready && prm_addr == '1) |=>
        (dat_we && dat_addr == '0 && dat_wdata == '0));

    // R5: ready holds once raised
    a_r5_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);

    // R7: drop flag is sticky
    a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        wr_drop_err |=> wr_drop_err);

    // R8: host write reaches the chosen port once ready
    a_r8_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && hst_we) |-> (hst_sel ? (dat_we && !prm_we) : (prm_we && !dat_we)));

    // R8: no write without a host request once ready
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !hst_we) |-> (!prm_we && !dat_we));

endmodule

bind param_boot_loader bl_checker #(
    .PAW    (PAW),
    .DAW    (DAW),
    .WORD_W (WORD_W)
) u_chk (.*);

// File: tb/sim_param_boot_loader.sv
// Scoreboard bench: the driver queues each expected memory write, and a
// monitor on the falling edge pops and compares every write the design makes.
module sim_param_boot_loader;
    localparam int WORD_W = 24;
    localparam int PAW    = 8;
    localparam int DAW    = 9;
    localparam int READY_CYC = 1025;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              hst_we = 1'b0;
    logic              hst_sel = 1'b0;
    logic [DAW-1:0]    hst_addr = '0;
    logic [WORD_W-1:0] hst_wdata = '0;
    logic              prm_we;
    logic [PAW-1:0]    prm_addr;
    logic [WORD_W-1:0] prm_wdata;
    logic              dat_we;
    logic [DAW-1:0]    dat_addr;
    logic [WORD_W-1:0] dat_wdata;
    logic              regs_clr;
    logic              ready;
    logic              wr_drop_err;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    logic rst_q   = 1'b0;
    logic exp_err = 1'b0;
    logic [DAW+WORD_W-1:0] pq[$];
    logic [DAW+WORD_W-1:0] dq[$];

    always #10 clk = ~clk;

    param_boot_loader u0 (
        .clk (clk), .rst_n (rst_n),
        .hst_we (hst_we), .hst_sel (hst_sel), .hst_addr (hst_addr), .hst_wdata (hst_wdata),
        .prm_we (prm_we), .prm_addr (prm_addr), .prm_wdata (prm_wdata),
        .dat_we (dat_we), .dat_addr (dat_addr), .dat_wdata (dat_wdata),
        .regs_clr (regs_clr), .ready (ready), .wr_drop_err (wr_drop_err)
    );

    function automatic logic [WORD_W-1:0] exp_coef(input int a);
        logic [31:0] p;
        p = (32'(a) * 32'd2654435761) ^ (32'(a) * 32'd128);
        return p[WORD_W-1:0];
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    // Bench model of cycle index and expected drop flag.
    always @(posedge clk) begin
        rst_q <= rst_n;
        if (!rst_n) begin
            cyc <= 0;
            exp_err <= 1'b0;
        end else begin
            if (hst_we && cyc < READY_CYC) exp_err <= 1'b1;
            cyc <= cyc + 1;
        end
    end

    // Monitor: compare outputs against the model and the expected queues.
    always @(negedge clk) begin
        if (!rst_q || cyc == 0) begin
            check(!prm_we && !dat_we && !regs_clr && !ready && !wr_drop_err, "R1",
                  "quiet in reset", {prm_we, dat_we, regs_clr, ready, wr_drop_err}, 0);
        end else begin
            check(regs_clr == (cyc == 1), "R2", "clear strobe", regs_clr, cyc == 1);
            check(ready == (cyc >= READY_CYC), "R5", "ready timing", ready, cyc >= READY_CYC);
            check(wr_drop_err == exp_err, "R7", "drop flag", wr_drop_err, exp_err);
            if (prm_we) begin
                if (pq.size() == 0) begin
                    check(0, ready ? "R8" : "R6", "unexpected param write", prm_addr, 0);
                end else begin
                    logic [DAW+WORD_W-1:0] e;
                    e = pq.pop_front();
                    check({1'b0, prm_addr, prm_wdata} == e, ready ? "R8" : "R3",
                          "param write", {1'b0, prm_addr, prm_wdata}, e);
                end
            end
            if (dat_we) begin
                if (dq.size() == 0) begin
                    check(0, ready ? "R8" : "R6", "unexpected sample write", dat_addr, 0);
                end else begin
                    logic [DAW+WORD_W-1:0] e;
                    e = dq.pop_front();
                    check({dat_addr, dat_wdata} == e, ready ? "R8" : "R4",
                          "sample write", {dat_addr, dat_wdata}, e);
                end
            end
        end
    end

    task automatic do_reset(input int n);
        rst_n = 1'b0;
        @(posedge clk); #2;
        pq.delete();
        dq.delete();
        repeat (n) begin @(posedge clk); #2; end
        rst_n = 1'b1;
        for (int a = 0; a < 256; a++) pq.push_back({1'b0, PAW'(a), exp_coef(a)});
        for (int a = 0; a < 512; a++) dq.push_back({DAW'(a), WORD_W'(0)});
    endtask

    task automatic wait_cyc(input int n);
        while (cyc != n) begin @(posedge clk); #2; end
    endtask

    task automatic hwrite(input bit sel, input int addr, input int data, input bit expect_it);
        hst_we = 1'b1;
        hst_sel = sel;
        hst_addr = DAW'(addr);
        hst_wdata = WORD_W'(data);
        if (expect_it) begin
            if (sel) dq.push_back({DAW'(addr), WORD_W'(data)});
            else     pq.push_back({1'b0, PAW'(addr), WORD_W'(data)});
        end
        @(posedge clk); #2;
        hst_we = 1'b0;
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        summary();
        $finish;
    end

    initial begin
        @(posedge clk); #2;
        do_reset(4);
        // R6/R7: host requests during the coefficient copy are dropped
        wait_cyc(50);
        hwrite(1'b0, 3, 24'h123456, 1'b0);
        hwrite(1'b1, 9, 24'hABCDEF, 1'b0);
        // R9: reset partway through the copy restarts everything
        wait_cyc(180);
        do_reset(3);
        // R6: request during the zeroing pass is dropped too
        wait_cyc(400);
        hwrite(1'b1, 140, 24'h55AA55, 1'b0);
        wait_cyc(1030);
        check(pq.size() == 0, "R3", "all table words written", pq.size(), 0);
        check(dq.size() == 0, "R4", "all sample words zeroed", dq.size(), 0);
        // R8: host writes pass through once ready; drop flag stays set (R7)
        hwrite(1'b0, 7, 24'hC0FFEE, 1'b1);
        hwrite(1'b1, 300, 24'h0BEEF1, 1'b1);
        hwrite(1'b1, 511, 24'hFFFFFF, 1'b1);
        hwrite(1'b0, 255, 24'h000001, 1'b1);
        repeat (3) begin @(posedge clk); #2; end
        check(pq.size() == 0 && dq.size() == 0, "R8", "host writes seen", pq.size() + dq.size(), 0);
        check(wr_drop_err == 1'b1, "R7", "flag held after ready", wr_drop_err, 1);
        // R7: a clean run after reset leaves the flag low
        do_reset(2);
        wait_cyc(1030);
        check(wr_drop_err == 1'b0, "R7", "flag cleared by reset", wr_drop_err, 0);
        check(ready == 1'b1, "R5", "ready after clean run", ready, 1);
        check(pq.size() == 0 && dq.size() == 0, "R9", "second full run complete", pq.size() + dq.size(), 0);
        summary();
        $finish;
    end

endmodule